// File: doc/BRIEF.md
# Toffoli Gate-List Reduction Unit

This block takes an ordered list of generalized Toffoli gate descriptors and deletes redundant gates without changing the permutation the list realizes. A gate flips one target line when each of its control lines matches a required polarity. The unit looks for a pair of identical gates that can be brought together by legal reordering and removes both gates. Two gates may trade places only when neither one's target line is among the other's controls. Two identical gates cancel when every gate between them could commute past the pair. The unit keeps making passes over the list until a whole pass removes nothing.

Gates arrive on a valid/ready input stream and are stored in order. The reduced list leaves on a valid/ready output stream, in its original relative order. Two plain status counters report how many gates remain and how many were removed. A descriptor is `{target, control_mask, polarity}`: bits [N_LINES-1:0] hold the polarity, bits [2*N_LINES-1:N_LINES] hold the control mask, and the top TW bits hold the target line index. Polarity bit 1 means the line must be 1 for the gate to fire. Polarity bit 0 means the line must be 0. The control mask must not include the target line, and the target index must be below N_LINES.

Back-pressure rules: the input side accepts a gate only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle or done. The output side holds `out_valid`, `out_gate` and `out_last` stable until `out_ready` takes the gate. A new input transfer made while `done` is high throws away the previous list and begins a new one.

Top module: `tofr_reducer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `busy`, `done`, `gate_count` and `removed_count` are all 0. Each accepted input gate is stored at the next position and raises `gate_count` by one, in the descriptor layout stated above.
- R2: A list ends when a gate is accepted with `in_last` high, or when the DEPTH-th gate is accepted. `gate_count` never exceeds DEPTH, and `in_ready` falls as soon as the list ends.
- R3: Two gates match only when they have the same target, the same control mask, and the same polarity on every line in that mask. Polarity bits outside the mask are ignored. Gates that do not match are never cancelled against each other.
- R4: Two matching gates that stand next to each other are both removed, so `removed_count` is always even when `done` is high.
- R5: Two matching gates with other gates between them are both removed only when two conditions hold. No gate between them has the pair's target in its control mask, and no gate between them has its target in the pair's control mask. For example, the list TOF(a,b;c) TOF(a;c) TOF(a,b;c) reduces to TOF(a;c).
- R6: Passes repeat until one full pass removes nothing, so the final list contains no removable pair. The gates that remain keep their order, the realized permutation does not change, and `gate_count` never grows during reduction.
- R7: During reduction, `gate_count + removed_count` stays equal to the number of gates loaded. Deletion closes the gap by moving one entry down per cycle.
- R8: After reduction, the remaining gates are sent in order on the output stream, with `out_last` high on the final gate only. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_gate` and `out_last` hold.
- R9: `done` rises in the cycle after the final output transfer. If the reduced list is empty, `done` rises with no output transfer at all. An input transfer made while `done` is high starts a new list with both counters cleared.
- R10: `busy` is high while the unit searches and compacts. During that time `in_ready` and `out_valid` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input gate valid |
| in_ready | output | 1 | Unit can accept a gate |
| in_gate | input | GW | Gate descriptor {target, control mask, polarity} |
| in_last | input | 1 | Marks the final gate of the list |
| out_valid | output | 1 | Output gate valid |
| out_ready | input | 1 | Consumer takes the output gate |
| out_gate | output | GW | Reduced-list gate descriptor |
| out_last | output | 1 | Final gate of the reduced list |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | Reduced list fully delivered |
| gate_count | output | CW | Gates currently held |
| removed_count | output | CW | Gates removed from the current list |

## Verification
On every cycle, the assertions check the stream rules and the counter rules. The output holds under back-pressure, and `in_ready` excludes both reduction and output. `gate_count` is bounded by DEPTH and never grows during reduction, the sum of the two counters stays constant, and the removed count is even when the unit is done. Only the bench's scenarios can show the parts that depend on list contents. These are that the realized permutation over all inputs does not change, that blocked pairs survive while compatible pairs cancel, that polarity bits outside the mask are ignored, and that cancellations enabled in a later pass are found. The bench also checks that the final list has no removable pair and that the exact gate order matches for the directed cases.

// File: rtl/tofr_pkg.sv
package tofr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SCAN  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } tofr_state_e;

endpackage

// File: rtl/tofr_pair_check.sv
// Compares a reference gate p with a candidate gate k.
// same     : k matches p (R3 rules).
// conflict : k cannot commute with p (R5 rules).
module tofr_pair_check #(
  parameter int N_LINES = 3,
  parameter int TW      = 2,
  parameter int GW      = 8
) (
  input  logic [GW-1:0] gate_p,
  input  logic [GW-1:0] gate_k,
  output logic          same,
  output logic          conflict
);

  logic [TW-1:0]      tgt_p, tgt_k;
  logic [N_LINES-1:0] ctl_p, ctl_k, pol_p, pol_k;
  logic [N_LINES-1:0] line_p, line_k;

  assign tgt_p = gate_p[GW-1 -: TW];
  assign tgt_k = gate_k[GW-1 -: TW];
  assign ctl_p = gate_p[2*N_LINES-1:N_LINES];
  assign ctl_k = gate_k[2*N_LINES-1:N_LINES];
  assign pol_p = gate_p[N_LINES-1:0];
  assign pol_k = gate_k[N_LINES-1:0];

  // One-hot line of each target.
  assign line_p = N_LINES'(1) << tgt_p;
  assign line_k = N_LINES'(1) << tgt_k;

  always_comb begin
    same     = (tgt_p == tgt_k) && (ctl_p == ctl_k) &&
               ((pol_p & ctl_p) == (pol_k & ctl_k));
    conflict = (|(ctl_k & line_p)) || (|(ctl_p & line_k));
  end

endmodule

// File: rtl/tofr_gate_store.sv
// Ordered gate storage: one write port, a single-entry shift-down, two reads.
module tofr_gate_store #(
  parameter int GW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [GW-1:0] wr_data,
  input  logic          sh_en,
  input  logic [AW-1:0] sh_idx,
  input  logic [AW-1:0] rd_a_idx,
  output logic [GW-1:0] rd_a,
  input  logic [AW-1:0] rd_b_idx,
  output logic [GW-1:0] rd_b
);

  logic [GW-1:0] ent [DEPTH];
  logic [GW-1:0] nxt [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [AW-1:0] EIDX = AW'(e);
    if (e < DEPTH - 1) begin : g_mid
      // Entry e takes the entry above it when the gap sits at e.
      assign nxt[e] = (wr_en && wr_idx == EIDX)  ? wr_data   :
                      (sh_en && sh_idx == EIDX)  ? ent[e+1]  : ent[e];
    end else begin : g_top
      assign nxt[e] = (wr_en && wr_idx == EIDX)  ? wr_data   : ent[e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ent[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) ent[e] <= nxt[e];
    end
  end

  assign rd_a = ent[rd_a_idx];
  assign rd_b = ent[rd_b_idx];

endmodule

// File: rtl/tofr_reducer.sv
module tofr_reducer
  import tofr_pkg::*;
#(
  parameter int  N_LINES = 3,
  parameter int  DEPTH   = 16,
  localparam int TW      = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int GW      = TW + 2 * N_LINES,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [GW-1:0] in_gate,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [GW-1:0] out_gate,
  output logic          out_last,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] gate_count,
  output logic [CW-1:0] removed_count
);

  localparam int            AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);

  tofr_state_e   state;
  logic [CW-1:0] cnt, rem;
  logic [CW-1:0] i_r, j_r;       // reference gate, candidate partner
  logic          blocked;        // a gate between i and j cannot commute
  logic          changed;        // this pass removed something
  logic [CW-1:0] sh_ptr, sh_sec; // current gap, second gap to close
  logic          sh_pend;
  logic [CW-1:0] out_ptr;

  logic [CW-1:0] ip1, jp1, shp1, outp1, load_base, new_cnt;
  logic          accept, wr_en, sh_en, same, conflict;
  logic [AW-1:0] wr_idx, rd_a_idx, rd_b_idx;
  logic [GW-1:0] gate_a, gate_b;

  assign ip1    = i_r + ONE;
  assign jp1    = j_r + ONE;
  assign shp1   = sh_ptr + ONE;
  assign outp1  = out_ptr + ONE;

  assign in_ready  = (state == ST_IDLE) || (state == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign load_base = (state == ST_DONE) ? '0 : cnt;
  assign new_cnt   = load_base + ONE;

  assign wr_en    = accept;
  assign wr_idx   = load_base[AW-1:0];
  assign sh_en    = (state == ST_SHIFT) && (shp1 < cnt);
  assign rd_a_idx = (state == ST_DRAIN) ? out_ptr[AW-1:0] : i_r[AW-1:0];
  assign rd_b_idx = j_r[AW-1:0];

  tofr_gate_store #(
    .GW    (GW),
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (in_gate),
    .sh_en    (sh_en),
    .sh_idx   (sh_ptr[AW-1:0]),
    .rd_a_idx (rd_a_idx),
    .rd_a     (gate_a),
    .rd_b_idx (rd_b_idx),
    .rd_b     (gate_b)
  );

  tofr_pair_check #(
    .N_LINES (N_LINES),
    .TW      (TW),
    .GW      (GW)
  ) u_pair (
    .gate_p   (gate_a),
    .gate_k   (gate_b),
    .same     (same),
    .conflict (conflict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rem     <= '0;
      i_r     <= '0;
      j_r     <= '0;
      blocked <= 1'b0;
      changed <= 1'b0;
      sh_ptr  <= '0;
      sh_sec  <= '0;
      sh_pend <= 1'b0;
      out_ptr <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            if (state == ST_DONE) rem <= '0;
            cnt <= new_cnt;
            if (in_last || new_cnt == FULL) begin
              state   <= ST_SCAN;
              i_r     <= '0;
              j_r     <= ONE;
              blocked <= 1'b0;
              changed <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_SCAN: begin
          if (ip1 >= cnt) begin
            // End of a pass.
            if (changed) begin
              i_r     <= '0;
              j_r     <= ONE;
              blocked <= 1'b0;
              changed <= 1'b0;
            end else begin
              state   <= (cnt == '0) ? ST_DONE : ST_DRAIN;
              out_ptr <= '0;
            end
          end else if (j_r >= cnt || blocked) begin
            // No partner possible for gate i: move on.
            i_r     <= ip1;
            j_r     <= ip1 + ONE;
            blocked <= 1'b0;
          end else if (same) begin
            // Remove the later gate first, then gate i.
            state   <= ST_SHIFT;
            sh_ptr  <= j_r;
            sh_sec  <= i_r;
            sh_pend <= 1'b1;
          end else begin
            blocked <= conflict;
            j_r     <= jp1;
          end
        end
        ST_SHIFT: begin
          if (shp1 < cnt) begin
            sh_ptr <= shp1;
          end else begin
            cnt <= cnt - ONE;
            rem <= rem + ONE;
            if (sh_pend) begin
              sh_ptr  <= sh_sec;
              sh_pend <= 1'b0;
            end else begin
              state   <= ST_SCAN;
              j_r     <= ip1;
              blocked <= 1'b0;
              changed <= 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (out_ready) begin
            if (outp1 >= cnt) state <= ST_DONE;
            else              out_ptr <= outp1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid     = (state == ST_DRAIN);
  assign out_gate      = gate_a;
  assign out_last      = (state == ST_DRAIN) && (outp1 == cnt);
  assign busy          = (state == ST_SCAN) || (state == ST_SHIFT);
  assign done          = (state == ST_DONE);
  assign gate_count    = cnt;
  assign removed_count = rem;

endmodule

// File: rtl/tofr_reducer_chk.sv
module tofr_reducer_chk #(
  parameter int  N_LINES = 3,
  parameter int  DEPTH   = 16,
  localparam int TW      = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int GW      = TW + 2 * N_LINES,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [GW-1:0] out_gate,
  input logic          out_last,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] gate_count,
  input logic [CW-1:0] removed_count
);

  logic [CW:0] total;
  assign total = {1'b0, gate_count} + {1'b0, removed_count};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    gate_count <= CW'(DEPTH)); // R2

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!busy && !out_valid)); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_gate) && $stable(out_last))); // R8

  AST_COUNT_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (total == $past(total))); // R7

  AST_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (gate_count <= $past(gate_count))); // R6

  AST_EVEN_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !removed_count[0]); // R4

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid)); // R9

endmodule

bind tofr_reducer tofr_reducer_chk #(
  .N_LINES (N_LINES),
  .DEPTH   (DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_gate      (out_gate),
  .out_last      (out_last),
  .busy          (busy),
  .done          (done),
  .gate_count    (gate_count),
  .removed_count (removed_count)
);

// File: tb/tb_tofr_reducer.sv
`timescale 1ns/1ps
module tb_tofr_reducer;

  localparam int N     = 3;
  localparam int DEPTH = 16;
  localparam int GW    = 8;
  localparam int CW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [GW-1:0] in_gate = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [GW-1:0] out_gate;
  logic          out_last;
  logic          busy, done;
  logic [CW-1:0] gate_count, removed_count;

  always #4 clk = ~clk;

  tofr_reducer #(.N_LINES(N), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_gate(in_gate), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_gate(out_gate), .out_last(out_last),
    .busy(busy), .done(done), .gate_count(gate_count), .removed_count(removed_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [GW-1:0] dl [DEPTH];
  logic [GW-1:0] el [DEPTH];
  logic [GW-1:0] ol [DEPTH];
  int n_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  function automatic logic [GW-1:0] mk(input int t, input logic [2:0] c, input logic [2:0] p);
    return {2'(t), c, p};
  endfunction

  // Apply a gate list to a 3-bit input value.
  function automatic int eval(input logic [GW-1:0] l [DEPTH], input int n, input int x);
    logic [2:0] v;
    v = 3'(x);
    for (int k = 0; k < n; k++) begin
      logic [2:0] c, p;
      int t;
      t = int'(l[k][7:6]);
      c = l[k][5:3];
      p = l[k][2:0];
      if (((~(v ^ p)) & c) == c) v[t] = ~v[t];
    end
    return int'(v);
  endfunction

  function automatic bit g_same(input logic [GW-1:0] a, input logic [GW-1:0] b);
    return (a[7:6] == b[7:6]) && (a[5:3] == b[5:3]) &&
           ((a[2:0] & a[5:3]) == (b[2:0] & b[5:3]));
  endfunction

  function automatic bit g_conf(input logic [GW-1:0] p, input logic [GW-1:0] k);
    return k[3 + int'(p[7:6])] || p[3 + int'(k[7:6])];
  endfunction

  function automatic bit reducible(input logic [GW-1:0] l [DEPTH], input int n);
    for (int i = 0; i < n; i++) begin
      bit blk;
      blk = 0;
      for (int j = i + 1; j < n; j++) begin
        if (!blk && g_same(l[i], l[j])) return 1;
        if (g_conf(l[i], l[j])) blk = 1;
      end
    end
    return 0;
  endfunction

  // Called at a negedge; returns at the negedge after the transfer.
  task automatic send(input logic [GW-1:0] g, input bit last);
    in_valid = 1'b1;
    in_gate  = g;
    in_last  = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic load(input int n, input bit use_last);
    for (int k = 0; k < n; k++) begin
      send(dl[k], use_last && (k == n - 1));
      if (k == 0 && n > 1)
        chk(gate_count == 1 && in_ready, "R1", "count after first gate", int'(gate_count), 1);
    end
    chk(busy && !in_ready, "R10", "busy and not ready after list end", int'(in_ready), 0);
  endtask

  task automatic collect();
    bit got_last, stall;
    logic [GW-1:0] held;
    int guard;
    n_out = 0; got_last = 0; guard = 0;
    while (!got_last && guard < 20000) begin
      if (done && !out_valid) break;
      out_ready = (($urandom % 4) != 0);
      stall = out_valid && !out_ready;
      held  = out_gate;
      if (out_valid && out_ready && n_out < DEPTH) begin
        ol[n_out] = out_gate;
        n_out++;
        chk(out_last == (n_out == int'(gate_count)), "R8", "last flag position",
            int'(out_last), int'(n_out == int'(gate_count)));
        if (out_last) got_last = 1;
      end
      @(negedge clk);
      guard++;
      if (stall)
        chk(out_valid && out_gate == held, "R8", "hold under back-pressure",
            int'(out_gate), int'(held));
    end
    out_ready = 1'b0;
    chk(done, "R9", "done after delivery", int'(done), 1);
  endtask

  task automatic run_directed(input string req, input int n, input bit use_last, input int n_exp);
    load(n, use_last);
    collect();
    chk(int'(gate_count) == n_exp, req, "remaining count", int'(gate_count), n_exp);
    chk(int'(removed_count) == n - n_exp, req, "removed count", int'(removed_count), n - n_exp);
    chk(n_out == n_exp, req, "gates delivered", n_out, n_exp);
    for (int k = 0; k < n_exp && k < n_out; k++)
      chk(ol[k] == el[k], req, "gate in order", int'(ol[k]), int'(el[k]));
    for (int x = 0; x < 8; x++)
      chk(eval(ol, n_out, x) == eval(dl, n, x), "R6", "permutation kept",
          eval(ol, n_out, x), eval(dl, n, x));
  endtask

  logic [GW-1:0] ga, gb, gc, gab;

  initial begin
    void'($urandom(32'd20240611));
    ga  = mk(2, 3'b001, 3'b001); // TOF(a;c)
    gb  = mk(1, 3'b100, 3'b100); // TOF(c;b)
    gc  = mk(0, 3'b010, 3'b010); // TOF(b;a)
    gab = mk(2, 3'b011, 3'b011); // TOF(a,b;c)

    repeat (5) @(negedge clk);
    chk(in_ready && !out_valid && !busy && !done && gate_count == 0 && removed_count == 0,
        "R1", "reset state", int'(gate_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !busy && !done, "R1", "idle after reset", int'(in_ready), 1);

    // R5: separated pair cancels across a compatible gate.
    dl[0] = gab; dl[1] = ga; dl[2] = gab; el[0] = ga;
    run_directed("R5", 3, 1, 1);

    // R4: adjacent identical pair.
    dl[0] = ga; dl[1] = ga;
    run_directed("R4", 2, 1, 0);

    // R5: intervening control on the pair's target blocks.
    dl[0] = ga; dl[1] = gb; dl[2] = ga; el[0] = ga; el[1] = gb; el[2] = ga;
    run_directed("R5", 3, 1, 3);

    // R5: intervening target in the pair's controls blocks.
    dl[0] = ga; dl[1] = gc; dl[2] = ga; el[0] = ga; el[1] = gc; el[2] = ga;
    run_directed("R5", 3, 1, 3);

    // R3: differing polarity on a controlled line never cancels.
    dl[0] = ga; dl[1] = mk(2, 3'b001, 3'b000); el[0] = dl[0]; el[1] = dl[1];
    run_directed("R3", 2, 1, 2);

    // R3: polarity bits outside the mask are ignored.
    dl[0] = mk(2, 3'b001, 3'b001); dl[1] = mk(2, 3'b001, 3'b111);
    run_directed("R3", 2, 1, 0);

    // R6: inner pair removal unblocks the outer pair in a later pass.
    dl[0] = ga; dl[1] = gb; dl[2] = gb; dl[3] = ga;
    run_directed("R6", 4, 1, 0);

    // R2: DEPTH gates with no last marker end the list on their own.
    for (int k = 0; k < DEPTH; k++) dl[k] = gab;
    run_directed("R2", DEPTH, 0, 0);

    // R9: a new list after done clears the removed count.
    dl[0] = ga; dl[1] = gc; dl[2] = ga; el[0] = ga; el[1] = gc; el[2] = ga;
    run_directed("R9", 3, 1, 3);

    // Random lists, many with repeated gates.
    for (int it = 0; it < 40; it++) begin
      int n;
      bit perm_ok;
      n = 1 + int'($urandom % DEPTH);
      for (int k = 0; k < n; k++) begin
        logic [2:0] c, p;
        int t;
        if (k > 0 && ($urandom % 2) == 1) begin
          int s;
          s = int'($urandom % k);
          c = dl[s][5:3];
          p = (dl[s][2:0] & c) | (3'($urandom) & ~c);
          dl[k] = {dl[s][7:3], p};
        end else begin
          t = int'($urandom % 3);
          c = 3'($urandom) & ~(3'b001 << t);
          p = 3'($urandom);
          dl[k] = mk(t, c, p);
        end
      end
      load(n, 1);
      collect();
      perm_ok = 1;
      for (int x = 0; x < 8; x++)
        if (eval(ol, n_out, x) != eval(dl, n, x)) perm_ok = 0;
      chk(perm_ok, "R6", "random permutation kept", int'(perm_ok), 1);
      chk(!reducible(ol, n_out), "R6", "random result irreducible", n_out, n_out);
      chk(int'(gate_count) == n_out, "R7", "random remaining count", int'(gate_count), n_out);
      chk(int'(removed_count) == n - n_out, "R7", "random removed count",
          int'(removed_count), n - n_out);
      chk(removed_count[0] == 1'b0, "R4", "random removal even", int'(removed_count), 0);
    end

    summary();
  end

endmodule